// File: doc/BRIEF.md
# UART Receive Byte Queue

This block buffers characters coming off a serial deserializer before the host collects them. Received bytes, and break conditions (which enter the queue as a zero byte), are stored in a small first-in first-out memory of parameterised depth. The host takes bytes out through a read strobe. A programmable fill threshold drives a level indication. A character-timeout detector flags data that has sat untouched for a number of character periods.

The host configures the queue with a single control byte. Bit 0 turns queued operation on. Bit 1 empties the receive side. Bit 2 requests a transmit-side flush, which this block passes on as a pulse. Bits 7:6 choose the fill threshold. With queued operation off, the block behaves as one holding register. Character periods are not timed here. An external strobe marks each elapsed character time.

Top module: `rx_byte_queue`

## Requirements
- R1: `count` reports the number of stored bytes (0 to DEPTH) one cycle after each push or read, and `data_ready` is high exactly when `count` is non-zero.
- R2: With control bit 0 set, `level_hit` is high when `count` is at least the threshold selected by control bits 7:6: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2, 11 gives DEPTH-2 (1, 4, 8, 14 at depth 16).
- R3: Bytes leave in arrival order. `rd_data` shows the oldest stored byte in the cycle after `rd_en`.
- R4: A byte arriving while the queue is full (queued mode) is discarded, stored bytes are kept, and `overrun` is set. A `stat_rd` strobe clears `overrun` and `brk_flag`.
- R5: In queued mode, a push, or a read that leaves data behind, restarts a timer of TMO_CHARS `char_tick` strobes. When the timer reaches TMO_CHARS while data is stored, `timeout_pend` sets. When it expires on an empty queue, nothing is flagged.
- R6: Any `rd_en` pulse clears `timeout_pend`.
- R7: A read that empties the queue clears `data_ready` and `brk_flag`.
- R8: `rx_break` stores a 0x00 byte and sets `brk_flag` and `data_ready`.
- R9: A control write with bit 1 set, or whose bit 0 differs from the current bit 0, empties the queue and cancels a pending timeout. A write with bit 2 set, or one that changes bit 0, pulses `tx_flush` for one cycle.
- R10: Only control bits 7, 6, 3 and 0 are kept (mask 0xC9, seen on `ctl_state`). A write equal to `ctl_state` has no effect, and a threshold change without a bit-0 change keeps the stored bytes.
- R11: With bit 0 clear, the block holds a single byte. A new byte replaces it, and if `data_ready` was already high, `overrun` is set.
- R12: A read from an empty queue returns 0x00 and leaves `count` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_tick | input | 1 | One-cycle strobe per elapsed character time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition strobe |
| rd_en | input | 1 | Host read of the receive buffer |
| rd_data | output | 8 | Byte returned by the last read |
| stat_rd | input | 1 | Host read of line status; clears overrun and break |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ctl_state | output | 8 | Retained control bits |
| count | output | $clog2(DEPTH)+1 | Stored byte count |
| data_ready | output | 1 | At least one byte stored |
| brk_flag | output | 1 | Break received |
| overrun | output | 1 | Byte lost |
| timeout_pend | output | 1 | Character timeout pending |
| level_hit | output | 1 | Fill threshold reached |
| tx_flush | output | 1 | Transmit-side flush pulse |

## Verification
The bench uses the defaults DEPTH = 16 and TMO_CHARS = 4. At these values a full queue, the 17th byte that must be dropped, and the 14-byte top threshold can each be reached within a few dozen cycles. Four strobes are also enough to tell a restarted timer from one left running. Because the depth is a power of two, pointer wrap-around is covered while the queue is filled and drained in full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic rx_clear;
    logic tx_clear;
  } flush_req_t;
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    state,
  output logic [CW-1:0] level,
  output flush_req_t    flush,
  output logic          tx_flush_q
);
  logic [7:0] ctl_q;
  logic       changed;
  logic       toggled;

  always_comb begin
    changed        = wr && (wdata != ctl_q);
    toggled        = wdata[0] ^ ctl_q[0];
    flush.rx_clear = changed && (wdata[1] || toggled);
    flush.tx_clear = changed && (wdata[2] || toggled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      tx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= flush.tx_clear;
      if (changed) ctl_q <= wdata & CTL_KEEP_MASK;
    end
  end

  always_comb begin
    case (trig_sel_e'(ctl_q[7:6]))
      TRIG_ONE:  level = CW'(1);
      TRIG_QTR:  level = CW'(DEPTH / 4);
      TRIG_HALF: level = CW'(DEPTH / 2);
      default:   level = CW'(DEPTH - 2);
    endcase
  end

  assign state = ctl_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_addr, rd_addr;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rd_q;
  logic          rd_zero_q;
  logic          full, nonempty, do_wr, do_rd;

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    nonempty = (cnt_q != '0);
    do_wr    = push && (single || !full);
    do_rd    = pop && nonempty;
    wr_addr  = single ? '0 : wr_ptr;
    rd_addr  = single ? '0 : rd_ptr;
  end

  // Synchronous write and read port: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_addr] <= wdata;
    if (pop)   rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)      rd_zero_q <= 1'b1;
    else if (pop) rd_zero_q <= !nonempty;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (single) begin
      if (do_wr)      cnt_q <= CW'(1);
      else if (do_rd) cnt_q <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata = rd_zero_q ? '0 : rd_q;
  assign count = cnt_q;
endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
  parameter int CHARS = 4,
  parameter int TW    = $clog2(CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cancel,
  input  logic tick,
  input  logic has_data,
  input  logic rd_clear,
  output logic pend
);
  logic [TW-1:0] tcnt;
  logic          armed;
  logic          fire;

  assign fire = armed && tick && !restart && (tcnt == TW'(CHARS - 1));

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      tcnt  <= '0;
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (restart) begin
        tcnt  <= '0;
        armed <= 1'b1;
      end else if (armed && tick) begin
        if (fire) armed <= 1'b0;
        else      tcnt  <= tcnt + 1'b1;
      end
      if (rd_clear)              pend <= 1'b0;
      else if (fire && has_data) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_tick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          stat_rd,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_state,
  output logic [CW-1:0] count,
  output logic          data_ready,
  output logic          brk_flag,
  output logic          overrun,
  output logic          timeout_pend,
  output logic          level_hit,
  output logic          tx_flush
);
  flush_req_t       flush;
  logic [CW-1:0]    level;
  logic             fifo_on, push, pop, full, nonempty;
  logic             ovr_evt, drain, restart;
  logic [BYTE_W-1:0] wbyte;
  logic             ovr_q, brk_q;

  rxq_ctl #(.DEPTH(DEPTH), .CW(CW)) ctl_i (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .state(ctl_state), .level(level), .flush(flush), .tx_flush_q(tx_flush)
  );

  always_comb begin
    fifo_on  = ctl_state[0];
    push     = (rx_valid || rx_break) && !flush.rx_clear;
    pop      = rd_en && !flush.rx_clear;
    wbyte    = rx_break ? '0 : rx_data;
    full     = (count == CW'(DEPTH));
    nonempty = (count != '0);
    ovr_evt  = push && (fifo_on ? full : nonempty);
    drain    = pop && (count <= CW'(1)) && !push;
    restart  = fifo_on && (push || (pop && (count > CW'(1))));
  end

  rxq_store #(.DEPTH(DEPTH), .DW(BYTE_W)) store_i (
    .clk(clk), .rst(rst), .clr(flush.rx_clear), .single(!fifo_on),
    .push(push), .pop(pop), .wdata(wbyte), .rdata(rd_data), .count(count)
  );

  rxq_tmo #(.CHARS(TMO_CHARS)) tmo_i (
    .clk(clk), .rst(rst), .restart(restart), .cancel(flush.rx_clear),
    .tick(char_tick), .has_data(nonempty), .rd_clear(rd_en), .pend(timeout_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
      if (rx_break && !flush.rx_clear) brk_q <= 1'b1;
      else if (stat_rd || drain)       brk_q <= 1'b0;
    end
  end

  assign overrun    = ovr_q;
  assign brk_flag   = brk_q;
  assign data_ready = nonempty;
  assign level_hit  = fifo_on ? (count >= level) : nonempty;
endmodule

// File: rtl/rx_byte_queue_chk.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rd_en,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_state,
  input logic [CW-1:0] count,
  input logic          data_ready,
  input logic          brk_flag,
  input logic          overrun,
  input logic          timeout_pend,
  input logic          tx_flush
);
  // R1
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  a_r4_full_keeps: assert property (@(posedge clk) disable iff (rst)
    (ctl_state[0] && count == CW'(DEPTH) && (rx_valid || rx_break) && !rd_en && !ctl_wr)
    |=> (overrun && count == CW'(DEPTH)));

  // R6
  a_r6_read_clears_pend: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !timeout_pend);

  // R8
  a_r8_break_marks: assert property (@(posedge clk) disable iff (rst)
    (rx_break && !ctl_wr) |=> (brk_flag && data_ready));

  // R9
  a_r9_rx_flush: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (ctl_wdata[1] || (ctl_wdata[0] != ctl_state[0])))
    |=> (count == '0 && !timeout_pend));

  // R9
  a_r9_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (ctl_wdata[2] || (ctl_wdata[0] != ctl_state[0]))) |=> tx_flush);

  // R11
  a_r11_single_cap: assert property (@(posedge clk) disable iff (rst)
    !ctl_state[0] |-> (count <= CW'(1)));
endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_break(rx_break),
  .rd_en(rd_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_state(ctl_state), .count(count), .data_ready(data_ready),
  .brk_flag(brk_flag), .overrun(overrun), .timeout_pend(timeout_pend),
  .tx_flush(tx_flush)
);

// File: tb/rx_byte_queue_tb_top.sv
module rx_byte_queue_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int NV    = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          char_tick = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rd_en = 1'b0, stat_rd = 1'b0, ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    rd_data, ctl_state;
  logic [CW-1:0] count;
  logic          data_ready, brk_flag, overrun, timeout_pend, level_hit, tx_flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rx_byte_queue #(.DEPTH(DEPTH), .TMO_CHARS(4)) dut_i (
    .clk(clk), .rst(rst), .char_tick(char_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data),
    .stat_rd(stat_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_state(ctl_state), .count(count), .data_ready(data_ready),
    .brk_flag(brk_flag), .overrun(overrun), .timeout_pend(timeout_pend),
    .level_hit(level_hit), .tx_flush(tx_flush)
  );

  // op(2) arg(8) expected count(5) expected read byte(8); op 0 push, 1 read, 2 control, 3 break
  localparam logic [22:0] VEC [NV] = '{
    {2'd2, 8'h01, 5'd0, 8'h00},
    {2'd0, 8'h11, 5'd1, 8'h00},
    {2'd0, 8'h22, 5'd2, 8'h00},
    {2'd0, 8'h33, 5'd3, 8'h00},
    {2'd1, 8'h00, 5'd2, 8'h11},
    {2'd1, 8'h00, 5'd1, 8'h22},
    {2'd3, 8'h00, 5'd2, 8'h00},
    {2'd1, 8'h00, 5'd1, 8'h33},
    {2'd1, 8'h00, 5'd0, 8'h00},
    {2'd1, 8'h00, 5'd0, 8'h00},
    {2'd0, 8'hA5, 5'd1, 8'h00},
    {2'd2, 8'h03, 5'd0, 8'h00},
    {2'd0, 8'h5A, 5'd1, 8'h00},
    {2'd1, 8'h00, 5'd0, 8'h5A}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic read_b();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic ctl_b(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask
  task automatic brk_b();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask
  task automatic tick_b(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); char_tick = 1'b1;
      @(negedge clk); char_tick = 1'b0;
    end
  endtask
  task automatic stat_b();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset count", int'(count), 0);
    check("R1 reset data_ready", int'(data_ready), 0);
    check("R4 reset overrun", int'(overrun), 0);
    check("R8 reset break", int'(brk_flag), 0);
    check("R5 reset timeout", int'(timeout_pend), 0);
    check("R10 reset control", int'(ctl_state), 0);
    check("R9 reset tx_flush", int'(tx_flush), 0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][22:21])
        2'd0: push_b(VEC[i][20:13]);
        2'd1: read_b();
        2'd2: ctl_b(VEC[i][20:13]);
        default: brk_b();
      endcase
      check($sformatf("R1 vector %0d count", i), int'(count), int'(VEC[i][12:8]));
      if (VEC[i][22:21] == 2'd1)
        check($sformatf("R3 vector %0d read", i), int'(rd_data), int'(VEC[i][7:0]));
    end

    // R2 thresholds, R10 threshold change keeps data
    ctl_b(8'h81);
    for (int i = 0; i < 7; i++) push_b(8'h10 + 8'(i));
    check("R2 level 8 below", int'(level_hit), 0);
    push_b(8'h17);
    check("R2 level 8 reached", int'(level_hit), 1);
    ctl_b(8'hC1);
    check("R10 threshold change keeps bytes", int'(count), 8);
    check("R2 level 14 below", int'(level_hit), 0);
    for (int i = 0; i < 6; i++) push_b(8'h20 + 8'(i));
    check("R2 level 14 reached", int'(level_hit), 1);
    ctl_b(8'h41);
    check("R2 level 4", int'(level_hit), 1);

    // R4 overrun on full queue
    ctl_b(8'h43);
    check("R9 receive reset", int'(count), 0);
    for (int i = 0; i < DEPTH; i++) push_b(8'h80 + 8'(i));
    check("R4 full count", int'(count), DEPTH);
    check("R4 no overrun yet", int'(overrun), 0);
    push_b(8'hEE);
    check("R4 overrun set", int'(overrun), 1);
    check("R4 count held", int'(count), DEPTH);
    read_b();
    check("R3 oldest first", int'(rd_data), 8'h80);
    for (int i = 1; i < DEPTH; i++) read_b();
    check("R4 last byte kept", int'(rd_data), 8'h8F);
    check("R7 drained", int'(data_ready), 0);
    check("R4 overrun sticky", int'(overrun), 1);
    stat_b();
    check("R4 status read clears", int'(overrun), 0);

    // R5 / R6 timeout
    push_b(8'h61);
    tick_b(3);
    check("R5 three ticks", int'(timeout_pend), 0);
    tick_b(1);
    check("R5 fourth tick", int'(timeout_pend), 1);
    tick_b(2);
    check("R5 stays pending", int'(timeout_pend), 1);
    read_b();
    check("R6 read clears pend", int'(timeout_pend), 0);
    check("R3 timeout byte", int'(rd_data), 8'h61);
    push_b(8'h71);
    push_b(8'h72);
    tick_b(4);
    check("R5 pend two bytes", int'(timeout_pend), 1);
    read_b();
    check("R6 pend cleared", int'(timeout_pend), 0);
    tick_b(3);
    check("R5 restart after read", int'(timeout_pend), 0);
    tick_b(1);
    check("R5 fires after restart", int'(timeout_pend), 1);
    ctl_b(8'h43);
    check("R9 reset cancels pend", int'(timeout_pend), 0);
    check("R9 reset empties", int'(count), 0);
    push_b(8'h01);
    read_b();
    tick_b(5);
    check("R5 empty queue no flag", int'(timeout_pend), 0);

    // R9 enable toggle
    push_b(8'h02);
    push_b(8'h03);
    ctl_b(8'h40);
    check("R9 toggle empties", int'(count), 0);
    check("R9 toggle tx_flush", int'(tx_flush), 1);
    @(negedge clk);
    check("R9 tx_flush one cycle", int'(tx_flush), 0);

    // R11 single holding register
    push_b(8'h41);
    check("R11 single held", int'(data_ready), 1);
    check("R11 no overrun", int'(overrun), 0);
    push_b(8'h42);
    check("R11 overrun on second", int'(overrun), 1);
    check("R11 single count", int'(count), 1);
    read_b();
    check("R11 newest kept", int'(rd_data), 8'h42);
    check("R7 single read clears ready", int'(data_ready), 0);
    stat_b();
    check("R4 status clears overrun", int'(overrun), 0);
    brk_b();
    check("R8 break sets flag", int'(brk_flag), 1);
    check("R8 break sets ready", int'(data_ready), 1);
    read_b();
    check("R8 break byte zero", int'(rd_data), 0);
    check("R7 empty read clears break", int'(brk_flag), 0);

    // R10 retained bits and equal write
    ctl_b(8'hFF);
    check("R10 retained mask", int'(ctl_state), 8'hC9);
    check("R9 bit2 tx_flush", int'(tx_flush), 1);
    push_b(8'h33);
    push_b(8'h34);
    ctl_b(8'hC9);
    check("R10 equal write keeps count", int'(count), 2);
    check("R10 equal write no flush", int'(tx_flush), 0);
    check("R10 equal write state", int'(ctl_state), 8'hC9);

    // R12 empty read
    read_b();
    check("R3 read a", int'(rd_data), 8'h33);
    read_b();
    check("R3 read b", int'(rd_data), 8'h34);
    read_b();
    check("R12 empty read data", int'(rd_data), 0);
    check("R12 empty read count", int'(count), 0);

    // R8 / R4 break in queued mode, cleared by status read
    brk_b();
    check("R8 queued break flag", int'(brk_flag), 1);
    stat_b();
    check("R4 status clears break", int'(brk_flag), 0);
    check("R1 break byte still stored", int'(data_ready), 1);
    read_b();
    check("R8 queued break byte", int'(rd_data), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule